// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory from reset to a usable state and then keeps its contents refreshed. After reset it drives only no-operation commands, with clock enable and the data mask lines held high, for a settle period set by a parameter. It then closes both banks with one precharge-all and issues a set number of auto refreshes. Next it loads the mode register with a parameter word that carries CAS latency, burst length, wrap type and write mode. A short wait follows, and then it raises `init_done`.

Once `init_done` is high, an interval timer posts a refresh request on `refresh_due`. The request stays posted until the sequencer issues an auto refresh. It does so only on a clock edge where the user port grants the bus, both banks report idle, and the row cycle time has passed since the previous refresh. If a whole further interval passes with the request still posted, a sticky error flag is set. Each wait (settle period, tRP, tRC, mode-set recovery, refresh interval) is a count of clock cycles.

Top module: `sdr_bringup_refresh`

## Requirements
- R1: Command code is {cs_n, ras_n, cas_n, we_n}: 0111 no-op, 0010 precharge, 0001 auto refresh, 0000 mode set. During reset and the settle period the code is 0111, CKE is 1, every DQM bit is 1, and `init_done`, `refresh_due` and `refresh_missed` are 0.
- R2: The precharge (0010) appears on the HOLD_CYC-th rising edge after reset is released. Address bit AP_BIT (10) is 1 and all other address bits are 0.
- R3: The first auto refresh appears exactly T_RP edges after the precharge.
- R4: INIT_REFS auto refreshes are issued in total, each T_RC edges after the one before. The mode set follows T_RC edges after the last of them.
- R5: During the mode set the address carries MODE_WORD and the bank select is 0.
- R6: `init_done` rises T_MRD edges after the mode set and then stays high. DQM bits are all 0 from the same edge on.
- R7: Before `init_done`, `bus_grant` and `banks_idle` have no effect on the command stream.
- R8: `refresh_due` rises REF_INTERVAL edges after `init_done` rises, and is posted again every REF_INTERVAL edges after that. It stays high until a refresh is issued.
- R9: An auto refresh is issued on an edge where `refresh_due`, `bus_grant` and `banks_idle` are all high and at least T_RC edges have passed since the previous refresh. `refresh_due` falls on that same edge, unless a new interval also ends on it.
- R10: With `bus_grant` or `banks_idle` low, no refresh is issued and the request stays posted.
- R11: `refresh_missed` is set when an interval ends while a request is still posted and is not serviced on that edge. Once set it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | User port hands the command bus to the sequencer |
| banks_idle | input | 1 | Both banks are precharged |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |
| sd_bank | output | BANK_W | Bank select |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | Bring-up complete |
| refresh_due | output | 1 | Refresh request posted |
| refresh_missed | output | 1 | Sticky missed-refresh flag |

## Verification
The assertions assume that `bus_grant` and `banks_idle` are clean synchronous levels, and that the user port tells the truth about bank state. The sequencer cannot check that the banks are really precharged; it only checks that it never refreshes without both inputs high on the edge before. The stimulus drives both inputs at the falling edge only, so no input ever changes near a rising edge. Long runs with no grant are used on purpose to reach the missed-refresh case, including a grant that lands exactly on the edge where the second interval ends.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        SEQ_NOP = 4'b0111,
        SEQ_PRE = 4'b0010,
        SEQ_REF = 4'b0001,
        SEQ_MRS = 4'b0000
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        BT_PRE    = 3'd0,
        BT_REF    = 3'd1,
        BT_MRS    = 3'd2,
        BT_SETTLE = 3'd3,
        BT_RUN    = 3'd4
    } boot_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdrseq_gap.sv
module sdrseq_gap #(
    parameter int GAP_W    = 16,
    parameter int INIT_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             open_o
);
    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= GAP_W'(INIT_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign open_o = (cnt_q == '0);
endmodule

// File: rtl/sdrseq_boot.sv
module sdrseq_boot
    import sdr_seq_pkg::*;
#(
    parameter int GAP_W     = 16,
    parameter int INIT_REFS = 2,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gap_open,
    output sdr_cmd_e         boot_cmd,
    output logic             boot_fire,
    output logic [GAP_W-1:0] boot_gap,
    output logic             ready
);
    localparam int RC_W = $clog2(INIT_REFS + 1);

    boot_state_e      state_q;
    logic [RC_W-1:0]  refs_q;

    always_comb begin
        boot_cmd  = SEQ_NOP;
        boot_fire = 1'b0;
        boot_gap  = '0;
        case (state_q)
            BT_PRE: begin
                boot_cmd  = SEQ_PRE;
                boot_fire = gap_open;
                boot_gap  = GAP_W'(T_RP - 1);
            end
            BT_REF: begin
                boot_cmd  = SEQ_REF;
                boot_fire = gap_open;
                boot_gap  = GAP_W'(T_RC - 1);
            end
            BT_MRS: begin
                boot_cmd  = SEQ_MRS;
                boot_fire = gap_open;
                boot_gap  = GAP_W'(T_MRD - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BT_PRE;
            refs_q  <= '0;
            ready   <= 1'b0;
        end else if (gap_open) begin
            case (state_q)
                BT_PRE: state_q <= BT_REF;
                BT_REF: begin
                    refs_q <= refs_q + 1'b1;
                    if (refs_q == RC_W'(INIT_REFS - 1))
                        state_q <= BT_MRS;
                end
                BT_MRS: state_q <= BT_SETTLE;
                BT_SETTLE: begin
                    state_q <= BT_RUN;
                    ready   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6
    ready_stay_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
endmodule

// File: rtl/sdrseq_tick.sv
module sdrseq_tick #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic serviced,
    output logic pending,
    output logic missed
);
    localparam int TMR_W = $clog2(REF_INTERVAL);

    logic [TMR_W-1:0] tmr_q;
    logic             due;

    assign due = run && (tmr_q == TMR_W'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q   <= '0;
            pending <= 1'b0;
            missed  <= 1'b0;
        end else if (run) begin
            tmr_q   <= due ? '0 : tmr_q + 1'b1;
            pending <= (pending && !serviced) || due;
            missed  <= missed || (due && pending && !serviced);
        end
    end

    // R8 R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !serviced) |=> pending);

    // R11
    miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        missed |=> missed);
endmodule

// File: rtl/sdr_bringup_refresh.sv
module sdr_bringup_refresh
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BANK_W       = 1,
    parameter int DQM_W        = 2,
    parameter int AP_BIT       = 10,
    parameter int HOLD_CYC     = 20000,
    parameter int INIT_REFS    = 2,
    parameter int T_RP         = 2,
    parameter int T_RC         = 7,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 1560,
    parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_grant,
    input  logic              banks_idle,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_bank,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done,
    output logic              refresh_due,
    output logic              refresh_missed
);
    localparam int GAP_MAX = max_of4(HOLD_CYC, T_RC, T_RP, T_MRD);
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    sdr_cmd_e         boot_cmd, cmd_d, cmd_q;
    logic             boot_fire, gap_open, run_fire, fire;
    logic [GAP_W-1:0] boot_gap, gap_val;
    logic [ADDR_W-1:0] addr_d, addr_q;

    sdrseq_gap #(.GAP_W(GAP_W), .INIT_VAL(HOLD_CYC - 1)) u_gap (
        .clk(clk), .rst(rst), .load(fire), .load_val(gap_val), .open_o(gap_open)
    );

    sdrseq_boot #(.GAP_W(GAP_W), .INIT_REFS(INIT_REFS), .T_RP(T_RP),
                  .T_RC(T_RC), .T_MRD(T_MRD)) u_boot (
        .clk(clk), .rst(rst), .gap_open(gap_open), .boot_cmd(boot_cmd),
        .boot_fire(boot_fire), .boot_gap(boot_gap), .ready(init_done)
    );

    sdrseq_tick #(.REF_INTERVAL(REF_INTERVAL)) u_tick (
        .clk(clk), .rst(rst), .run(init_done), .serviced(run_fire),
        .pending(refresh_due), .missed(refresh_missed)
    );

    assign run_fire = init_done && refresh_due && bus_grant && banks_idle && gap_open;
    assign fire     = init_done ? run_fire : boot_fire;
    assign gap_val  = init_done ? GAP_W'(T_RC - 1) : boot_gap;

    always_comb begin
        if (init_done)
            cmd_d = run_fire ? SEQ_REF : SEQ_NOP;
        else
            cmd_d = boot_fire ? boot_cmd : SEQ_NOP;
        case (cmd_d)
            SEQ_PRE: addr_d = ADDR_W'(1) << AP_BIT;
            SEQ_MRS: addr_d = MODE_WORD;
            default: addr_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= SEQ_NOP;
            addr_q <= '0;
        end else begin
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_addr = addr_q;
    assign sd_bank = '0;
    assign sd_cke  = 1'b1;
    assign sd_dqm  = {DQM_W{~init_done}};

    // Edges since the last refresh on the pins, saturating
    logic [GAP_W-1:0] since_ref_q;
    always_ff @(posedge clk) begin
        if (rst)
            since_ref_q <= GAP_W'(T_RC);
        else if (cmd_q == SEQ_REF)
            since_ref_q <= GAP_W'(1);
        else if (since_ref_q < GAP_W'(T_RC))
            since_ref_q <= since_ref_q + 1'b1;
    end

    // R4 R9
    always_ff @(posedge clk) begin
        if (!rst && cmd_q == SEQ_REF)
            trc_gap_chk: assert (since_ref_q >= GAP_W'(T_RC))
                else $error("refresh closer than tRC");
    end

    // R9 R10
    ref_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && cmd_q == SEQ_REF) |-> $past(bus_grant && banks_idle));

    // R2
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == SEQ_PRE) |-> (sd_addr[AP_BIT] && !init_done));
endmodule

// File: tb/sdr_bringup_refresh_bench.sv
module sdr_bringup_refresh_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 12;
    localparam int AP    = 10;
    localparam int HOLD  = 40;
    localparam int REFS  = 3;
    localparam int TRP   = 2;
    localparam int TRC   = 7;
    localparam int TMRD  = 2;
    localparam int IVL   = 60;
    localparam logic [AW-1:0] MODE = 12'h032;

    localparam int P_N   = HOLD;
    localparam int R0_N  = P_N + TRP;
    localparam int M_N   = R0_N + REFS * TRC;
    localparam int RDY_N = M_N + TMRD;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_grant = 1'b0, banks_idle = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, done, due, missed;
    logic [AW-1:0] addr;
    logic [0:0] bank;
    logic [1:0] dqm;

    int checks = 0, fails = 0, n = 0;
    int m_tmr, m_since;
    bit m_pend, m_miss;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_bringup_refresh #(
        .ADDR_W(AW), .BANK_W(1), .DQM_W(2), .AP_BIT(AP), .HOLD_CYC(HOLD),
        .INIT_REFS(REFS), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
        .REF_INTERVAL(IVL), .MODE_WORD(MODE)
    ) u_sdr_bringup_refresh (
        .clk(clk), .rst(rst), .bus_grant(bus_grant), .banks_idle(banks_idle),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(addr), .sd_bank(bank), .sd_cke(cke), .sd_dqm(dqm),
        .init_done(done), .refresh_due(due), .refresh_missed(missed)
    );

    function automatic logic [3:0] cmd_now();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic logic [3:0] exp_boot(input int k);
        if (k == P_N) return C_PRE;
        if (k == M_N) return C_MRS;
        for (int i = 0; i < REFS; i++)
            if (k == R0_N + i * TRC) return C_REF;
        return C_NOP;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at edge %0d: got %0h expected %0h", tag, n, act, exp);
        end
    endtask

    task automatic step(input bit g, input bit id);
        bus_grant  = g;
        banks_idle = id;
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    task automatic run_init();
        logic [3:0] e;
        rst = 1'b1;
        bus_grant = 1'b1; banks_idle = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(cmd_now() == C_NOP, "R1 reset cmd", cmd_now(), C_NOP);
        chk(cke == 1'b1 && dqm == 2'b11, "R1 reset cke/dqm", {cke, dqm}, 3'b111);
        chk({done, due, missed} == 3'b000, "R1 reset flags", {done, due, missed}, 0);
        rst = 1'b0;
        n = 0;
        while (n < RDY_N) begin
            step($urandom % 2, $urandom % 2);
            e = exp_boot(n);
            if (n < P_N)
                chk(cmd_now() == e && dqm == 2'b11 && cke, "R1 hold", {cmd_now(), dqm}, {e, 2'b11});
            else if (n == P_N) begin
                chk(cmd_now() == e, "R2 precharge", cmd_now(), e);
                chk(addr == (AW'(1) << AP), "R2 precharge addr", addr, AW'(1) << AP);
            end else if (n == R0_N)
                chk(cmd_now() == e, "R3 first refresh", cmd_now(), e);
            else if (n == M_N) begin
                chk(cmd_now() == e, "R4 mode after tRC", cmd_now(), e);
                chk(addr == MODE && bank == 1'b0, "R5 mode word", {bank, addr}, {1'b0, MODE});
            end else
                chk(cmd_now() == e, "R4 bring-up spacing", cmd_now(), e);
            if (e != C_REF)
                chk(cmd_now() != C_REF, "R7 grant ignored", cmd_now(), e);
            chk(done == (n >= RDY_N), "R6 ready edge", done, n >= RDY_N);
        end
        chk(dqm == 2'b00, "R6 dqm released", dqm, 0);
        m_tmr = 0; m_pend = 0; m_miss = 0; m_since = TRC;
    endtask

    task automatic run_step(input bit g, input bit id);
        bit issue, dueev;
        string tag;
        issue = m_pend && g && id && (m_since >= TRC - 1);
        dueev = (m_tmr == IVL - 1);
        tag = (m_pend && !(g && id)) ? "R10 blocked" : "R9 refresh issue";
        step(g, id);
        m_tmr   = dueev ? 0 : m_tmr + 1;
        m_miss  = m_miss || (dueev && m_pend && !issue);
        m_pend  = (m_pend && !issue) || dueev;
        m_since = issue ? 0 : (m_since < 1000 ? m_since + 1 : m_since);
        chk(cmd_now() == (issue ? C_REF : C_NOP), tag, cmd_now(), issue ? C_REF : C_NOP);
        chk(due == m_pend, "R8 refresh_due", due, m_pend);
        chk(missed == m_miss, "R11 missed flag", missed, m_miss);
        chk(done && dqm == 2'b00, "R6 stays ready", {done, dqm}, 3'b100);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R6: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int dens;
        void'($urandom(32'd2877));
        @(negedge clk);
        run_init();

        // R8: first request exactly IVL edges after ready, no grant
        for (int k = 0; k < IVL; k++) run_step(1'b0, 1'b1);
        chk(due == 1'b1, "R8 first due at interval", due, 1);

        // random traffic in segments of varying grant density
        for (int seg = 0; seg < 10; seg++) begin
            dens = $urandom % 5;
            for (int k = 0; k < 150; k++)
                run_step(($urandom % 4) < dens, ($urandom % 3) != 0);
        end

        // directed: service exactly on the edge a second interval ends
        run_init();
        for (int k = 0; k < 2 * IVL - 1; k++) run_step(1'b0, 1'b1);
        run_step(1'b1, 1'b1);
        chk(missed == 1'b0, "R11 boundary service no miss", missed, 0);
        chk(cmd_now() == C_REF, "R9 boundary refresh", cmd_now(), C_REF);

        // busy banks block the refresh
        for (int k = 0; k < 10; k++) run_step(1'b1, 1'b0);
        for (int k = 0; k < IVL; k++) run_step(1'b0, 1'b1);
        chk(missed == 1'b1, "R11 miss set", missed, 1);
        for (int k = 0; k < 3 * IVL; k++) run_step(1'b1, 1'b1);
        chk(missed == 1'b1, "R11 miss sticky", missed, 1);

        // reset clears everything and bring-up repeats
        run_init();
        for (int k = 0; k < 2 * IVL; k++) run_step(1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule